// File: doc/BRIEF.md
# Broadcast audio decoder control port (two-wire bus slave)

This block gives an external bus master control of a broadcast audio decoder over the two-wire I2C bus. It samples the clock and data lines into the system clock domain and finds start and stop conditions. It accepts a transaction only when the 7-bit address matches `101101X`. The low address bit X is taken from a strap input, so two decoders can share one bus.

A write carries a register pointer byte, then any number of data bytes. The data bytes go into three control registers. After each byte the pointer steps forward, and it returns to zero after the last register. A read returns three bytes that the decoder core supplies: status, error count and auxiliary data.

The register fields are driven straight to the decoder core as parallel outputs. One bit of the first register drives a general-purpose output pin.

Top module: `aud_ctl_i2c_slave`

## Requirements
- R1: After reset, control register 0 reads 0x90, register 1 (upper error limit) reads 0x50, register 2 (lower error limit) reads 0x14, `port_o` is 0 and `sda_oe_o` is 0.
- R2: An address byte is acknowledged only when its upper seven bits equal {1,0,1,1,0,1,`addr_sel_i`}. Acknowledging means driving SDA low during the ninth clock. Any other address gets no acknowledge, and the rest of that transaction leaves every register unchanged.
- R3: The all-zero general call address is never acknowledged, whatever the level of `addr_sel_i`.
- R4: In a write, the first byte after the address loads the register pointer. Each following byte is acknowledged and written into the register the pointer names.
- R5: After each data byte the pointer advances by one, and it goes from 2 back to 0, so a fourth byte after pointer 0 lands in register 0 again.
- R6: When the pointer is above 2, data bytes are still acknowledged but no register changes.
- R7: Register 0 bit 7 drives `mode_sel_o` and bit 6 drives `dual_sel_o`. Bits 5:3 drive `src_sel_o[2:0]`, bit 2 drives `port_o`, bit 1 drives `mute_def_o` and bit 0 drives `auto_mute_dis_o`. Register 1 drives `err_hi_o` and register 2 drives `err_lo_o`.
- R8: SDA is open-drain: `sda_oe_o` high means pull the line low. It changes only while SCL is low, and it is 0 after a stop condition.
- R9: A read transaction returns `status_i`, then `errcnt_i`, then `aux_i`, most significant bit first, and then starts again at `status_i`. Every read transaction begins at `status_i`.
- R10: When the master does not acknowledge a read byte, the block releases SDA and sends nothing more until the next start.
- R11: A start condition in the middle of a transaction, with no stop before it, restarts address decoding at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| addr_sel_i | input | 1 | Strap giving the lowest address bit |
| status_i | input | 8 | Decoder status byte for reads |
| errcnt_i | input | 8 | Error-count byte for reads |
| aux_i | input | 8 | Auxiliary data byte for reads |
| mode_sel_o | output | 1 | Dual-mono channel choice |
| dual_sel_o | output | 1 | Dual-mono one/both output choice |
| src_sel_o | output | 3 | Source and gain selection code |
| port_o | output | 1 | General-purpose output pin |
| mute_def_o | output | 1 | Default mute behaviour bit |
| auto_mute_dis_o | output | 1 | Automatic mute disable |
| err_hi_o | output | 8 | Upper error-count limit |
| err_lo_o | output | 8 | Lower error-count limit |

## Verification
The assertions assume that SCL is slow compared with the system clock. SDA is also assumed to change only while SCL is low, except for the SDA edges that form start and stop conditions. Under those assumptions the synchronised clock sees every bit and the output enable cannot change in a high phase.

The bench master holds every SCL phase for several system clocks. It moves SDA only after a low phase has settled, and it always ends a read with a not-acknowledge, so the slave has let go of SDA before a stop is sent.

// File: rtl/aud_ctl_pkg.sv
package aud_ctl_pkg;
  localparam int unsigned NUM_REGS = 3;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK} bus_st_t;
  typedef enum logic [1:0] {PH_ADDR, PH_SUB, PH_DATA} phase_t;

  function automatic logic [7:0] reg_reset(input int unsigned idx);
    case (idx)
      0:       return 8'h90;
      1:       return 8'h50;
      default: return 8'h14;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edges while the clock stays high
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import aud_ctl_pkg::*;
#(
  parameter int unsigned NREG  = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [7:0]                wr_data,
  output logic [NREG-1:0][7:0]      regs_o
);
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)
        regs_o[i] <= reg_reset(i);
      else if (wr_en && wr_idx == IDX_W'(i))
        regs_o[i] <= wr_data;
    end
  end
endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import aud_ctl_pkg::*;
#(
  parameter logic [5:0]  ADDR_HI = 6'b101101,
  parameter int unsigned NREG    = 3,
  parameter int unsigned IDX_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sda_s,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic                 addr_sel_i,
  input  logic [NREG-1:0][7:0] rd_bytes_i,
  output logic                 sda_oe_o,
  output logic                 wr_en_o,
  output logic [IDX_W-1:0]     wr_idx_o,
  output logic [7:0]           wr_data_o
);
  localparam logic [7:0]       LAST_PTR = 8'(NREG - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

  bus_st_t          st;
  phase_t           ph;
  logic [7:0]       sh;
  logic [3:0]       bcnt;
  logic             rw;
  logic             mack;
  logic [7:0]       ptr;
  logic [IDX_W-1:0] rd_idx, rd_nxt;
  logic [7:0]       tx_cur, tx_nxt;
  logic [6:0]       own_addr;

  assign own_addr = {ADDR_HI, addr_sel_i};
  assign rd_nxt   = (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;

  always_comb begin
    tx_cur = '0;
    tx_nxt = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == IDX_W'(i)) tx_cur = rd_bytes_i[i];
      if (rd_nxt == IDX_W'(i)) tx_nxt = rd_bytes_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;   ph <= PH_ADDR;   sh <= '0;     bcnt <= '0;
      rw <= 1'b0;      mack <= 1'b0;    ptr <= '0;    rd_idx <= '0;
      sda_oe_o <= 1'b0; wr_en_o <= 1'b0; wr_idx_o <= '0; wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        st <= ST_RX;  ph <= PH_ADDR;  bcnt <= '0;  sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE;  sda_oe_o <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && bcnt < 4'd8) begin
              sh   <= {sh[6:0], sda_s};
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              bcnt <= '0;
              case (ph)
                PH_ADDR: begin
                  if (sh[7:1] == own_addr) begin
                    rw <= sh[0];  rd_idx <= '0;  ph <= PH_SUB;
                    sda_oe_o <= 1'b1;  st <= ST_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                PH_SUB: begin
                  ptr <= sh;  ph <= PH_DATA;
                  sda_oe_o <= 1'b1;  st <= ST_ACK;
                end
                default: begin
                  sda_oe_o <= 1'b1;  st <= ST_ACK;
                  if (ptr <= LAST_PTR) begin
                    wr_en_o   <= 1'b1;
                    wr_idx_o  <= ptr[IDX_W-1:0];
                    wr_data_o <= sh;
                    ptr       <= (ptr == LAST_PTR) ? '0 : ptr + 8'd1;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bcnt <= '0;
              if (rw) begin
                sh <= tx_cur;  sda_oe_o <= ~tx_cur[7];  st <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;  st <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bcnt == 4'd7) begin
                sda_oe_o <= 1'b0;  st <= ST_RACK;
              end else begin
                sh       <= {sh[6:0], 1'b0};
                sda_oe_o <= ~sh[6];
                bcnt     <= bcnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                rd_idx <= rd_nxt;  sh <= tx_nxt;  bcnt <= '0;
                sda_oe_o <= ~tx_nxt[7];  st <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/aud_ctl_i2c_slave.sv
module aud_ctl_i2c_slave
  import aud_ctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [5:0]  ADDR_HI     = 6'b101101
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       addr_sel_i,
  input  logic [7:0] status_i,
  input  logic [7:0] errcnt_i,
  input  logic [7:0] aux_i,
  output logic       mode_sel_o,
  output logic       dual_sel_o,
  output logic [2:0] src_sel_o,
  output logic       port_o,
  output logic       mute_def_o,
  output logic       auto_mute_dis_o,
  output logic [7:0] err_hi_o,
  output logic [7:0] err_lo_o
);
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0] wr_data;
  logic [NUM_REGS-1:0][7:0] regs;
  logic [NUM_REGS-1:0][7:0] rd_bytes;

  assign rd_bytes = {aux_i, errcnt_i, status_i};

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_proto_fsm #(.ADDR_HI(ADDR_HI), .NREG(NUM_REGS), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .addr_sel_i(addr_sel_i),
    .rd_bytes_i(rd_bytes), .sda_oe_o(sda_oe_o), .wr_en_o(wr_en),
    .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  ctl_reg_bank #(.NREG(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .regs_o(regs)
  );

  assign {mode_sel_o, dual_sel_o, src_sel_o, port_o, mute_def_o, auto_mute_dis_o} = regs[0];
  assign err_hi_o = regs[1];
  assign err_lo_o = regs[2];
endmodule

// File: rtl/aud_ctl_i2c_chk.sv
module aud_ctl_i2c_chk #(
  parameter int unsigned IDX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_s,
  input logic             stop_det,
  input logic             sda_oe_o,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [7:0]       wr_data,
  input logic             port_o,
  input logic [7:0]       err_hi_o,
  input logic [7:0]       err_lo_o
);
  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

  p_stop_release_r8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe_o);

  p_wr_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx <= IDX_W'(2)));

  p_port_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(0)) |=> (port_o == $past(wr_data[2])));

  p_hi_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == IDX_W'(1)) |=> $stable(err_hi_o));

  p_lo_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == IDX_W'(2)) |=> $stable(err_lo_o));
endmodule

bind aud_ctl_i2c_slave aud_ctl_i2c_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_det(stop_det), .sda_oe_o(sda_oe_o),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .port_o(port_o),
  .err_hi_o(err_hi_o), .err_lo_o(err_lo_o)
);

// File: tb/aud_ctl_i2c_slave_tb_top.sv
module aud_ctl_i2c_slave_tb_top;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic addr_sel = 1'b0;
  logic [7:0] status_v = 8'h3C, errcnt_v = 8'h81, aux_v = 8'h5E;
  logic sda_oe;
  logic mode_sel, dual_sel, port, mute_def, amdis;
  logic [2:0] src_sel;
  logic [7:0] err_hi, err_lo;
  wire  sda_line = ~(m_low | sda_oe);
  wire  [7:0] ctl_obs = {mode_sel, dual_sel, src_sel, port, mute_def, amdis};

  int n_chk = 0, n_fail = 0;
  int model [3];
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aud_ctl_i2c_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .status_i(status_v), .errcnt_i(errcnt_v), .aux_i(aux_v),
    .mode_sel_o(mode_sel), .dual_sel_o(dual_sel), .src_sel_o(src_sel), .port_o(port),
    .mute_def_o(mute_def), .auto_mute_dis_o(amdis), .err_hi_o(err_hi), .err_lo_o(err_lo)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model compared every clock while the bus is quiet
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R7 ctl reg vs model", int'(ctl_obs), model[0]);
      chk("R7 hi reg vs model", int'(err_hi), model[1]);
      chk("R7 lo reg vs model", int'(err_lo), model[2]);
      chk("R8 sda released when idle", int'(sda_oe), 0);
    end
  end

  task automatic wait_hp(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    cmp_en = 1'b0;
    m_low = 1'b0; wait_hp(HP);
    m_scl = 1'b1; wait_hp(HP);
    m_low = 1'b1; wait_hp(HP);
    m_scl = 1'b0; wait_hp(HP);
  endtask

  task automatic bus_stop;
    m_low = 1'b1; wait_hp(HP);
    m_scl = 1'b1; wait_hp(HP);
    m_low = 1'b0; wait_hp(HP);
    cmp_en = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wait_hp(HP);
      m_scl = 1'b1;  wait_hp(HP);
      m_scl = 1'b0;  wait_hp(HP);
    end
    m_low = 1'b0; wait_hp(HP);
    m_scl = 1'b1; wait_hp(HP / 2);
    acked = ~sda_line;
    wait_hp(HP / 2);
    m_scl = 1'b0; wait_hp(HP);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wait_hp(HP);
      m_scl = 1'b1; wait_hp(HP);
      b[i] = sda_line;
      m_scl = 1'b0;
    end
    wait_hp(HP);
    m_low = give_ack; wait_hp(HP);
    m_scl = 1'b1; wait_hp(HP);
    m_scl = 1'b0; wait_hp(HP);
    m_low = 1'b0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] rb;
    model[0] = 'h90; model[1] = 'h50; model[2] = 'h14;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wait_hp(4);
    chk("R1 ctl reset", int'(ctl_obs), 'h90);
    chk("R1 hi reset", int'(err_hi), 'h50);
    chk("R1 lo reset", int'(err_lo), 'h14);
    chk("R1 port reset", int'(port), 0);
    chk("R1 sda reset", int'(sda_oe), 0);
    cmp_en = 1'b1;
    wait_hp(20);

    // sel=0 write burst with wrap
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'hB4, a); chk("R2 addr ack sel0", int'(a), 1);
    send_byte(8'h00, a); chk("R4 sub ack", int'(a), 1);
    send_byte(8'h2C, a); chk("R4 data0 ack", int'(a), 1); model[0] = 'h2C;
    send_byte(8'h61, a); chk("R4 data1 ack", int'(a), 1); model[1] = 'h61;
    send_byte(8'h07, a); chk("R4 data2 ack", int'(a), 1); model[2] = 'h07;
    send_byte(8'hA5, a); chk("R5 wrap ack", int'(a), 1);  model[0] = 'hA5;
    bus_stop();
    wait_hp(10);
    chk("R5 wrap landed reg0", int'(ctl_obs), 'hA5);
    chk("R7 port bit2", int'(port), 1);
    chk("R7 src bits5_3", int'(src_sel), 4);
    chk("R7 mode bit7", int'(mode_sel), 1);
    chk("R7 amdis bit0", int'(amdis), 1);

    // wrong strap level: address ...1 while sel=0
    bus_start();
    send_byte(8'hB6, a); chk("R2 mismatch nack", int'(a), 0);
    send_byte(8'h01, a);
    send_byte(8'hEE, a);
    bus_stop();
    wait_hp(10);
    chk("R2 mismatch no write", int'(err_hi), 'h61);

    // sel=1
    addr_sel = 1'b1;
    bus_start();
    send_byte(8'hB6, a); chk("R2 addr ack sel1", int'(a), 1);
    send_byte(8'h01, a);
    send_byte(8'h33, a); model[1] = 'h33;
    bus_stop();
    wait_hp(10);
    chk("R4 sel1 write hi", int'(err_hi), 'h33);

    // general call with both strap levels
    bus_start();
    send_byte(8'h00, a); chk("R3 gcall nack sel1", int'(a), 0);
    bus_stop();
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'h00, a); chk("R3 gcall nack sel0", int'(a), 0);
    bus_stop();
    addr_sel = 1'b1;

    // pointer out of range
    bus_start();
    send_byte(8'hB6, a);
    send_byte(8'h05, a); chk("R6 bad sub ack", int'(a), 1);
    send_byte(8'hFF, a); chk("R6 bad data ack", int'(a), 1);
    send_byte(8'hFF, a);
    bus_stop();
    wait_hp(10);
    chk("R6 ctl unchanged", int'(ctl_obs), 'hA5);
    chk("R6 lo unchanged", int'(err_lo), 'h07);

    // start at pointer 2, wrap to 0
    bus_start();
    send_byte(8'hB6, a);
    send_byte(8'h02, a);
    send_byte(8'h11, a); model[2] = 'h11;
    send_byte(8'h22, a); model[0] = 'h22;
    bus_stop();
    wait_hp(10);
    chk("R5 ptr2 wrap lo", int'(err_lo), 'h11);
    chk("R5 ptr2 wrap ctl", int'(ctl_obs), 'h22);
    chk("R7 port cleared", int'(port), 0);

    // read burst with wrap and final nack
    bus_start();
    send_byte(8'hB7, a); chk("R9 read addr ack", int'(a), 1);
    recv_byte(1'b1, rb); chk("R9 byte0 status", int'(rb), 'h3C);
    recv_byte(1'b1, rb); chk("R9 byte1 errcnt", int'(rb), 'h81);
    recv_byte(1'b1, rb); chk("R9 byte2 aux", int'(rb), 'h5E);
    recv_byte(1'b0, rb); chk("R9 byte3 wraps", int'(rb), 'h3C);
    wait_hp(HP);
    chk("R10 release after nack", int'(sda_oe), 0);
    m_scl = 1'b1; wait_hp(HP);
    chk("R10 line high after nack", int'(sda_line), 1);
    m_scl = 1'b0; wait_hp(HP);
    bus_stop();
    wait_hp(10);
    chk("R8 released after stop", int'(sda_oe), 0);

    // repeated start: write header then read
    status_v = 8'h96;
    bus_start();
    send_byte(8'hB6, a);
    send_byte(8'h01, a);
    bus_start();
    send_byte(8'hB7, a); chk("R11 restart addr ack", int'(a), 1);
    recv_byte(1'b0, rb); chk("R11 restart reads status", int'(rb), 'h96);
    bus_stop();
    wait_hp(10);
    chk("R11 restart no write", int'(err_hi), 'h33);

    // restart while reading, new read starts at status
    bus_start();
    send_byte(8'hB7, a);
    recv_byte(1'b1, rb);
    recv_byte(1'b0, rb); chk("R9 second byte errcnt", int'(rb), 'h81);
    bus_start();
    send_byte(8'hB7, a);
    recv_byte(1'b0, rb); chk("R9 new read at status", int'(rb), 'h96);
    bus_stop();
    wait_hp(20);

    done = 1'b1;
    report();
    $finish;
  end
endmodule